// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Fast Vectors

The controller gathers interrupt request lines from a set of peripheral sources. It picks one request to hand to the processor. Each source has a 2-bit priority code in a bank of priority words. A code of zero switches the source off. The codes 1, 2 and 3 place it at level 0, 1 or 2. Level 3 is reserved for the core and is never produced by a source. A 2-bit mask input from the core sets the lowest level that may interrupt. Among the unmasked pending requests, the one at the highest level wins. When levels are equal, the lower source number wins. The winning source number is the vector number.

For an ordinary interrupt, the vector address is formed from a programmable base plus a fixed two-word entry per vector. Two fast slots each hold a vector number to compare against and a handler address, split over a low word and a high word. If the winner matches a slot and sits at level 2, the controller replaces the table address with that slot's handler address and raises a fast flag. This decision is made before the core sees the request. Software reaches the configuration through a simple word-wide register port. The core acknowledges the vector it takes. A source whose vector has been acknowledged stays out of arbitration until its line has dropped.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every configuration register reads zero, `req_o`, `fast_o`, `vec_o` and `vaddr_o` are zero, and no request is presented even with every `irq_i` line high.
- R2: Register map (word address, 16-bit data). Addresses 0 and 1 are the priority words. Address 2 is the vector base. Address 3 is fast slot 0's match number and address 4 is fast slot 1's match number. Addresses 5 and 6 are slot 0's address low and high words. Addresses 7 and 8 are slot 1's address low and high words. A write takes effect at the clock edge. `reg_rdata_o` shows the addressed register one edge after `reg_addr_i` is applied, with unused bits zero.
- R3: Source i uses bits [2*(i%8)+1 : 2*(i%8)] of priority word i/8. Code 0 disables the source, and codes 1, 2 and 3 give levels 0, 1 and 2.
- R4: Among eligible sources the highest level wins. At equal level the lower source number wins. `vec_o` carries the winning source number.
- R5: Mask 00 admits levels 0 to 2. Mask 01 blocks level 0. Mask 10 blocks levels 0 and 1. Mask 11 blocks every source level, so `req_o` stays low.
- R6: For a normal interrupt, `vaddr_o` = ({base, 5'b0}) + 2 × vector number, and `fast_o` = 0.
- R7: A level-2 winner whose number equals a slot's match number is presented with `fast_o` = 1 and `vaddr_o` = {high word[4:0], low word} of that slot.
- R8: A winner at level 0 or 1 that equals a match number is presented as a normal interrupt (R6).
- R9: When both slots hold the winner's number, slot 0's handler address is used.
- R10: Pulsing `ack_i` for one cycle while `req_o` is high removes the presented vector from the next cycle onward, and the next eligible winner appears instead. That source stays excluded while its line remains high. It becomes eligible again once the line has been low for two cycles and is raised again.
- R11: An `irq_i` change reaches the outputs after two clock edges, and a `mask_i` change after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | N_SRC | Level-sensitive request line per source |
| mask_i | input | 2 | Core mask level |
| ack_i | input | 1 | Core takes the presented vector |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | RAW | Register word address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Registered read data |
| req_o | output | 1 | A vector is presented |
| vec_o | output | VW | Presented vector number |
| vaddr_o | output | AW | Vector address (table entry or fast handler) |
| fast_o | output | 1 | Presented vector is a fast interrupt |

## Verification
Acknowledge and fast-slot redirection can land in the same cycle. This happens when the core takes a fast vector while a second level-2 source that matches the other slot is waiting. The bench sets up two level-2 sources, one matching each slot, and acknowledges the first. It then checks that the very next presentation carries the second source's number, the other slot's handler address and the fast flag. It also checks that the acknowledged source does not come back while its line stays high.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef logic [1:0] lvl_code_t;

  function automatic logic [1:0] code_level(input lvl_code_t c);
    return 2'(c - 2'd1);
  endfunction

  localparam int FAST_LEVEL = 2;
  localparam int FIELDS_PER_WORD_SHIFT = 1;
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs #(
  parameter int N_SRC = 16,
  parameter int DW    = 16,
  parameter int AW    = 21,
  parameter int VW    = 4,
  parameter int NPR   = 2,
  parameter int RAW   = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [RAW-1:0]               addr,
  input  logic [DW-1:0]                wdata,
  output logic [DW-1:0]                rdata,
  output prio_irq_pkg::lvl_code_t [N_SRC-1:0] codes,
  output logic [DW-1:0]                base_word,
  output logic [VW-1:0]                match0,
  output logic [VW-1:0]                match1,
  output logic [AW-1:0]                hand0,
  output logic [AW-1:0]                hand1
);
  localparam int FPW   = DW / 2;
  localparam int HW    = AW - DW;
  localparam int A_VBA = NPR;
  localparam int A_M0  = NPR + 1;
  localparam int A_M1  = NPR + 2;
  localparam int A_L0  = NPR + 3;
  localparam int A_H0  = NPR + 4;
  localparam int A_L1  = NPR + 5;
  localparam int A_H1  = NPR + 6;

  logic [DW-1:0] pr_q [NPR];
  logic [DW-1:0] vba_q, lo0_q, lo1_q;
  logic [VW-1:0] m0_q, m1_q;
  logic [HW-1:0] hi0_q, hi1_q;

  genvar g;
  generate
    for (g = 0; g < NPR; g++) begin : g_pr
      always_ff @(posedge clk) begin
        if (rst) pr_q[g] <= '0;
        else if (we && int'(addr) == g) pr_q[g] <= wdata;
      end
    end
    for (g = 0; g < N_SRC; g++) begin : g_code
      assign codes[g] = pr_q[g / FPW][2*(g % FPW) +: 2];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      vba_q <= '0; m0_q <= '0; m1_q <= '0;
      lo0_q <= '0; hi0_q <= '0; lo1_q <= '0; hi1_q <= '0;
    end else if (we) begin
      if (int'(addr) == A_VBA) vba_q <= wdata;
      if (int'(addr) == A_M0)  m0_q  <= wdata[VW-1:0];
      if (int'(addr) == A_M1)  m1_q  <= wdata[VW-1:0];
      if (int'(addr) == A_L0)  lo0_q <= wdata;
      if (int'(addr) == A_H0)  hi0_q <= wdata[HW-1:0];
      if (int'(addr) == A_L1)  lo1_q <= wdata;
      if (int'(addr) == A_H1)  hi1_q <= wdata[HW-1:0];
    end
  end

  logic [DW-1:0] rmux;
  always_comb begin
    rmux = '0;
    if (int'(addr) < NPR)        rmux = pr_q[addr[$clog2(NPR+1)-1:0] < NPR ? int'(addr) : 0];
    else if (int'(addr) == A_VBA) rmux = vba_q;
    else if (int'(addr) == A_M0)  rmux = DW'(m0_q);
    else if (int'(addr) == A_M1)  rmux = DW'(m1_q);
    else if (int'(addr) == A_L0)  rmux = lo0_q;
    else if (int'(addr) == A_H0)  rmux = DW'(hi0_q);
    else if (int'(addr) == A_L1)  rmux = lo1_q;
    else if (int'(addr) == A_H1)  rmux = DW'(hi1_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rmux;
  end

  assign base_word = vba_q;
  assign match0    = m0_q;
  assign match1    = m1_q;
  assign hand0     = {hi0_q, lo0_q};
  assign hand1     = {hi1_q, lo1_q};
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int N_SRC = 16,
  parameter int VW    = 4
) (
  input  logic [N_SRC-1:0]                    elig,
  input  prio_irq_pkg::lvl_code_t [N_SRC-1:0] codes,
  input  logic [1:0]                          mask,
  output logic                                found,
  output logic [VW-1:0]                       win_vec,
  output logic [1:0]                          win_lvl
);
  always_comb begin
    found   = 1'b0;
    win_vec = '0;
    win_lvl = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i] && codes[i] != 2'd0 &&
          prio_irq_pkg::code_level(codes[i]) >= mask) begin
        if (!found || prio_irq_pkg::code_level(codes[i]) >= win_lvl) begin
          found   = 1'b1;
          win_lvl = prio_irq_pkg::code_level(codes[i]);
          win_vec = VW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/prio_irq_vec.sv
module prio_irq_vec #(
  parameter int DW = 16,
  parameter int AW = 21,
  parameter int VW = 4
) (
  input  logic [VW-1:0] vec,
  input  logic [1:0]    lvl,
  input  logic [DW-1:0] base_word,
  input  logic [VW-1:0] match0,
  input  logic [VW-1:0] match1,
  input  logic [AW-1:0] hand0,
  input  logic [AW-1:0] hand1,
  output logic [AW-1:0] vaddr,
  output logic          fast
);
  localparam int SH = AW - DW;

  logic          lvl_ok, hit0, hit1;
  logic [AW-1:0] table_addr;

  assign lvl_ok     = (int'(lvl) == prio_irq_pkg::FAST_LEVEL);
  assign hit0       = lvl_ok && (vec == match0);
  assign hit1       = lvl_ok && (vec == match1);
  assign table_addr = {base_word, {SH{1'b0}}} + (AW'(vec) << 1);

  always_comb begin
    fast  = hit0 || hit1;
    if (hit0)      vaddr = hand0;
    else if (hit1) vaddr = hand1;
    else           vaddr = table_addr;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_SRC = 16,
  parameter int DW    = 16,
  parameter int AW    = 21,
  parameter int VW    = $clog2(N_SRC),
  parameter int NPR   = (N_SRC + DW/2 - 1) / (DW/2),
  parameter int RAW   = $clog2(NPR + 7)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_i,
  input  logic [1:0]       mask_i,
  input  logic             ack_i,
  input  logic             reg_we_i,
  input  logic [RAW-1:0]   reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             req_o,
  output logic [VW-1:0]    vec_o,
  output logic [AW-1:0]    vaddr_o,
  output logic             fast_o
);
  prio_irq_pkg::lvl_code_t [N_SRC-1:0] codes;
  logic [DW-1:0]    base_word;
  logic [VW-1:0]    match0, match1, win_vec;
  logic [AW-1:0]    hand0, hand1, nx_addr;
  logic [N_SRC-1:0] pend_q, held_q, elig, taken;
  logic [1:0]       win_lvl;
  logic             found, nx_fast;

  prio_irq_regs #(.N_SRC(N_SRC), .DW(DW), .AW(AW), .VW(VW), .NPR(NPR), .RAW(RAW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we_i), .addr(reg_addr_i), .wdata(reg_wdata_i),
    .rdata(reg_rdata_o), .codes(codes), .base_word(base_word),
    .match0(match0), .match1(match1), .hand0(hand0), .hand1(hand1));

  always_comb begin
    taken = '0;
    if (ack_i && req_o) taken[vec_o] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      held_q <= '0;
    end else begin
      pend_q <= irq_i;
      held_q <= taken | (held_q & pend_q);
    end
  end

  assign elig = pend_q & ~held_q & ~taken;

  prio_irq_arb #(.N_SRC(N_SRC), .VW(VW)) u_arb (
    .elig(elig), .codes(codes), .mask(mask_i),
    .found(found), .win_vec(win_vec), .win_lvl(win_lvl));

  prio_irq_vec #(.DW(DW), .AW(AW), .VW(VW)) u_vec (
    .vec(win_vec), .lvl(win_lvl), .base_word(base_word),
    .match0(match0), .match1(match1), .hand0(hand0), .hand1(hand1),
    .vaddr(nx_addr), .fast(nx_fast));

  always_ff @(posedge clk) begin
    if (rst || !found) begin
      req_o   <= 1'b0;
      vec_o   <= '0;
      vaddr_o <= '0;
      fast_o  <= 1'b0;
    end else begin
      req_o   <= 1'b1;
      vec_o   <= win_vec;
      vaddr_o <= nx_addr;
      fast_o  <= nx_fast;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int VW = 4,
  parameter int AW = 21
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    mask_i,
  input logic          ack_i,
  input logic          req_o,
  input logic [VW-1:0] vec_o,
  input logic [AW-1:0] vaddr_o,
  input logic          fast_o
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !req_o); // R1
  AST_TOP_MASK_SILENT: assert property (@(posedge clk) disable iff (rst)
    (mask_i == 2'b11) |=> !req_o); // R5
  AST_TABLE_ADDR_EVEN: assert property (@(posedge clk) disable iff (rst)
    (req_o && !fast_o) |-> !vaddr_o[0]); // R6
  AST_FAST_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    fast_o |-> req_o); // R7
  AST_ACK_WITHDRAWS: assert property (@(posedge clk) disable iff (rst)
    (ack_i && req_o) |=> !(req_o && vec_o == $past(vec_o))); // R10
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.VW(VW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mask_i(mask_i), .ack_i(ack_i), .req_o(req_o),
  .vec_o(vec_o), .vaddr_o(vaddr_o), .fast_o(fast_o));

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int DW = 16;
  localparam int AW = 21;
  localparam int VW = 4;
  localparam int RAW = 4;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] irq;
  logic [1:0] mask;
  logic ack, we;
  logic [RAW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic req, fast;
  logic [VW-1:0] vec;
  logic [AW-1:0] vaddr;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] prw [2];
  logic [DW-1:0] vba_sh;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst(rst), .irq_i(irq), .mask_i(mask), .ack_i(ack),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .req_o(req), .vec_o(vec), .vaddr_o(vaddr), .fast_o(fast));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    we = 1'b1; addr = RAW'(a); wdata = d;
    step(1);
    we = 1'b0;
    if (a == 2) vba_sh = d;
  endtask

  task automatic set_code(input int src, input logic [1:0] c);
    prw[src/8][2*(src%8) +: 2] = c;
    wr(src/8, prw[src/8]);
  endtask

  function automatic logic [AW-1:0] tbl(input int v);
    return {vba_sh, 5'b0} + AW'(2*v);
  endfunction

  task automatic expect_out(input string tag, input logic r, input int v,
                            input logic [AW-1:0] a, input logic f);
    chk({tag, " req"}, 32'(req), 32'(r));
    if (r) begin
      chk({tag, " vec"}, 32'(vec), 32'(v));
      chk({tag, " addr"}, 32'(vaddr), 32'(a));
      chk({tag, " fast"}, 32'(fast), 32'(f));
    end
  endtask

  task automatic quiesce();
    irq = '0; mask = 2'b00;
    step(4);
  endtask

  task automatic t_reset();
    irq = '1;
    step(3);
    expect_out("R1 all lines high", 1'b0, 0, '0, 1'b0);
    chk("R1 vaddr zero", 32'(vaddr), 0);
    for (int a = 0; a < 9; a++) begin
      addr = RAW'(a);
      step(1);
      chk("R1 reg reads zero", 32'(rdata), 0);
    end
    quiesce();
  endtask

  task automatic t_regs();
    wr(2, 16'h0123);
    wr(3, 16'hFFFA);
    wr(5, 16'hBEEF);
    wr(6, 16'hFFFA);
    wr(7, 16'h1234);
    wr(8, 16'h0003);
    addr = 4'd2; step(1); chk("R2 base", 32'(rdata), 32'h0123);
    addr = 4'd3; step(1); chk("R2 match0 width", 32'(rdata), 32'h000A);
    addr = 4'd5; step(1); chk("R2 low0", 32'(rdata), 32'hBEEF);
    addr = 4'd6; step(1); chk("R2 high0 width", 32'(rdata), 32'h001A);
    addr = 4'd8; step(1); chk("R2 high1", 32'(rdata), 32'h0003);
    wr(3, 16'h000F);
    wr(4, 16'h000F);
  endtask

  task automatic t_arb();
    set_code(3, 2'd1);
    set_code(7, 2'd2);
    set_code(9, 2'd2);
    addr = 4'd0; step(1); chk("R3 field placement word0", 32'(rdata), 32'h8040);
    addr = 4'd1; step(1); chk("R3 field placement word1", 32'(rdata), 32'h0008);
    irq = '0; irq[3] = 1; irq[7] = 1; irq[9] = 1; irq[12] = 1;
    step(2);
    expect_out("R4 tie lower index", 1'b1, 7, tbl(7), 1'b0);
    chk("R6 table address", 32'(vaddr), 32'(21'h00246E));
    irq[7] = 0; irq[9] = 0;
    step(2);
    expect_out("R4 level0 left", 1'b1, 3, tbl(3), 1'b0);
    irq[12] = 0; irq[3] = 0;
    step(2);
    expect_out("R3 disabled source", 1'b0, 0, '0, 1'b0);
    quiesce();
  endtask

  task automatic t_mask();
    set_code(13, 2'd3);
    irq = '0; irq[3] = 1;
    step(2);
    expect_out("R5 mask00 level0", 1'b1, 3, tbl(3), 1'b0);
    mask = 2'b01;
    step(1);
    expect_out("R5 R11 mask01 blocks level0", 1'b0, 0, '0, 1'b0);
    irq[7] = 1;
    step(1);
    chk("R11 one edge not yet", 32'(req), 0);
    step(1);
    expect_out("R11 R5 mask01 level1", 1'b1, 7, tbl(7), 1'b0);
    mask = 2'b10;
    step(1);
    expect_out("R5 mask10 blocks level1", 1'b0, 0, '0, 1'b0);
    irq[13] = 1;
    step(2);
    expect_out("R5 mask10 level2", 1'b1, 13, tbl(13), 1'b0);
    mask = 2'b11;
    step(1);
    expect_out("R5 mask11 silent", 1'b0, 0, '0, 1'b0);
    quiesce();
  endtask

  task automatic t_fast();
    set_code(10, 2'd3);
    wr(3, 16'd10);
    irq = '0; irq[10] = 1;
    step(2);
    expect_out("R7 slot0 fast", 1'b1, 10, 21'h1ABEEF, 1'b1);
    wr(3, 16'd4);
    wr(4, 16'd10);
    step(1);
    expect_out("R7 slot1 fast", 1'b1, 10, 21'h031234, 1'b1);
    wr(3, 16'd10);
    step(1);
    expect_out("R9 both slots slot0", 1'b1, 10, 21'h1ABEEF, 1'b1);
    irq = '0; step(2);
    wr(4, 16'd7);
    irq[7] = 1;
    step(2);
    expect_out("R8 level1 match normal", 1'b1, 7, tbl(7), 1'b0);
    quiesce();
  endtask

  task automatic t_ack();
    set_code(12, 2'd3);
    wr(3, 16'd12);
    wr(4, 16'd10);
    irq = '0; irq[10] = 1; irq[12] = 1;
    step(2);
    expect_out("R10 first fast", 1'b1, 10, 21'h031234, 1'b1);
    ack = 1'b1; step(1); ack = 1'b0;
    expect_out("R10 R7 ack then other slot", 1'b1, 12, 21'h1ABEEF, 1'b1);
    step(3);
    expect_out("R10 still excluded", 1'b1, 12, 21'h1ABEEF, 1'b1);
    ack = 1'b1; step(1); ack = 1'b0;
    expect_out("R10 both taken", 1'b0, 0, '0, 1'b0);
    irq[10] = 0;
    step(3);
    irq[10] = 1;
    step(2);
    expect_out("R10 re-raised", 1'b1, 10, 21'h031234, 1'b1);
    quiesce();
  endtask

  initial begin
    rst = 1'b1; irq = '0; mask = 2'b00; ack = 1'b0; we = 1'b0;
    addr = '0; wdata = '0; prw[0] = '0; prw[1] = '0; vba_sh = '0;
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_regs();
    t_arb();
    t_mask();
    t_fast();
    t_ack();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule